// File: doc/BRIEF.md
# Five-Stage Pipeline with a Shared Memory Port

This block is a small in-order processor core with five stages: fetch, decode with register read, execute, memory access and write-back. It runs register-to-register arithmetic, add-immediate, word loads and word stores. One single-port memory outside the block holds both code and data. Each stage takes one cycle. Every pipeline register carries its instruction's decoded control beside the operands.

A load or store that reaches the memory stage uses the port in the same cycle as an instruction fetch would. The core gives the port to the data access. The fetch waits one cycle and a bubble enters the pipeline behind the waiting instruction. The bubble travels to write-back as an empty slot. The waiting instruction is fetched on the following cycle. The core has no forwarding. The register file passes a value that write-back is writing straight to the decode read in the same cycle, so a result can be used by the third instruction fetched after its producer. Two counters report retired instructions and inserted bubbles.

The memory is word-addressed. Reads are combinational from `mem_addr`, and a write takes effect at the clock edge of a cycle with `mem_wen` high. Reset is synchronous and active high.

Top module: `pipe5_shared`

## Requirements
- R1: While `rst` is high, `ret_valid` and `mem_wen` are 0, both counters are 0 and `mem_addr` is 0. In the first cycle after release the core fetches from address 0, and the register file reads as all zeros.
- R2: Instruction fields are opcode [31:26], source A [25:21], source B [20:16], destination [15:11], function [5:0] and immediate [15:0]. Opcode 0x00 is register-to-register. Its function codes are add 0, subtract 1, and 2, or 3, xor 4 and signed set-less-than 5. Each writes its result to the destination register.
- R3: Opcode 0x01 writes source A plus the sign-extended immediate into the register named by the source B field.
- R4: Opcode 0x02 loads the word at (source A + sign-extended immediate) mod 2^AW into the source B register. Negative offsets and wrap past the top of memory both follow that formula.
- R5: Register 0 always reads as zero. An instruction that names it as destination retires with `ret_we` = 0.
- R6: A value written in write-back is seen by the decode read in the same cycle, so the third instruction fetched after a producer reads the new value.
- R7: When there are no loads or stores, the instruction fetched k-th after reset retires in cycle k+4, and N instructions finish in N+4 cycles.
- R8: In a cycle when a load or store is in the memory stage, `mem_addr` carries its data address and no fetch takes place. The address the fetch would have used appears in the next cycle, and a one-cycle bubble reaches write-back four cycles after the fetch was skipped.
- R9: Loads and stores that follow one another each cost one bubble. The waiting fetch resumes as soon as the port is free.
- R10: `ret_count` rises by one for each retiring instruction, bubbles excluded. `bubble_count` rises by one for each cycle in which a fetch was skipped.
- R11: Opcode 0x03 drives `mem_wen` high for exactly its memory-stage cycle. In that cycle `mem_wdata` is the source B register and the address follows the R4 formula. The store retires with `ret_we` = 0.
- R12: Any other opcode, or an unlisted function code, retires as a no-op: no register write and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Word address of the shared memory port |
| mem_wen | output | 1 | Store strobe for the shared port |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Combinational read data (instruction or load word) |
| ret_valid | output | 1 | An instruction is in write-back this cycle |
| ret_we | output | 1 | That instruction writes a register |
| ret_rd | output | 5 | Destination register of the retiring instruction |
| ret_data | output | XLEN | Value being written back |
| ret_count | output | CW | Retired instruction count |
| bubble_count | output | CW | Inserted bubble count |

## Verification
The hardest cases to reach from the ports are runs of loads and stores back to back and the exact-distance write-back bypass. In a back-to-back run a fetch is deferred more than once, and every deferral shifts the retire cycle of every later instruction. The stimulus is built from programs in which the bench assembles each instruction word and works out its fetch cycle, counting every cycle in which a fetch was skipped. From this it predicts, for every cycle, the address on the port, the store strobe and data, and the retire cycle, value and both counter readings of each instruction. A dependent instruction placed exactly three fetches after its producer exercises the same-cycle register bypass. Memory words at negative offsets and past the address wrap are loaded to confirm the address arithmetic.

// File: rtl/pipe5_shared.sv
module pipe5_shared #(
  parameter int AW   = 10,
  parameter int XLEN = 32,
  parameter int CW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_wen,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            ret_valid,
  output logic            ret_we,
  output logic [4:0]      ret_rd,
  output logic [XLEN-1:0] ret_data,
  output logic [CW-1:0]   ret_count,
  output logic [CW-1:0]   bubble_count
);

  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);
  localparam int IW   = 32;

  localparam logic [5:0] OP_RR    = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h01;
  localparam logic [5:0] OP_LOAD  = 6'h02;
  localparam logic [5:0] OP_STORE = 6'h03;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_e;

  // fetch
  logic [AW-1:0]   pc;
  logic            fd_v;
  logic [IW-1:0]   fd_ir;

  // decode
  logic [5:0]      id_op, id_fn;
  logic [RW-1:0]   id_rs, id_rt, id_rd, id_dst;
  logic [XLEN-1:0] id_imm, id_a, id_b;
  alu_e            id_alu;
  logic            id_known, id_useimm, id_ld, id_st, id_wen;

  // execute
  logic            de_v, de_useimm, de_ld, de_st, de_wen;
  alu_e            de_alu;
  logic [RW-1:0]   de_dst;
  logic [XLEN-1:0] de_a, de_b, de_imm, ex_opb, ex_res;

  // memory
  logic            em_v, em_ld, em_st, em_wen;
  logic [RW-1:0]   em_dst;
  logic [XLEN-1:0] em_res, em_sd;
  logic            stall;

  // write-back
  logic            mw_v, mw_wen;
  logic [RW-1:0]   mw_dst;
  logic [XLEN-1:0] mw_val;
  logic            wb_wr;

  logic [XLEN-1:0] rf [NREG];

  // ---------------- shared port arbitration ----------------
  assign stall     = em_v & (em_ld | em_st);
  assign mem_addr  = stall ? em_res[AW-1:0] : pc;
  assign mem_wen   = em_v & em_st;
  assign mem_wdata = em_sd;

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      fd_v  <= 1'b0;
      fd_ir <= '0;
    end else if (stall) begin
      fd_v  <= 1'b0;
    end else begin
      pc    <= pc + AW'(1);
      fd_v  <= 1'b1;
      fd_ir <= mem_rdata[IW-1:0];
    end
  end

  // ---------------- decode ----------------
  assign id_op  = fd_ir[31:26];
  assign id_rs  = fd_ir[25:21];
  assign id_rt  = fd_ir[20:16];
  assign id_rd  = fd_ir[15:11];
  assign id_fn  = fd_ir[5:0];
  assign id_imm = {{(XLEN-16){fd_ir[15]}}, fd_ir[15:0]};

  always_comb begin
    id_alu    = ALU_ADD;
    id_known  = 1'b0;
    id_useimm = 1'b0;
    id_ld     = 1'b0;
    id_st     = 1'b0;
    id_dst    = id_rt;
    case (id_op)
      OP_RR: begin
        id_dst = id_rd;
        case (id_fn)
          6'd0: begin id_alu = ALU_ADD; id_known = 1'b1; end
          6'd1: begin id_alu = ALU_SUB; id_known = 1'b1; end
          6'd2: begin id_alu = ALU_AND; id_known = 1'b1; end
          6'd3: begin id_alu = ALU_OR;  id_known = 1'b1; end
          6'd4: begin id_alu = ALU_XOR; id_known = 1'b1; end
          6'd5: begin id_alu = ALU_SLT; id_known = 1'b1; end
          default: ;
        endcase
      end
      OP_ADDI:  begin id_known = 1'b1; id_useimm = 1'b1; end
      OP_LOAD:  begin id_known = 1'b1; id_useimm = 1'b1; id_ld = 1'b1; end
      OP_STORE: begin id_useimm = 1'b1; id_st = 1'b1; end
      default: ;
    endcase
  end

  assign id_wen = id_known && (id_dst != '0);

  assign wb_wr = mw_v & mw_wen;
  assign id_a  = (id_rs == '0) ? '0 :
                 (wb_wr && mw_dst == id_rs) ? mw_val : rf[id_rs];
  assign id_b  = (id_rt == '0) ? '0 :
                 (wb_wr && mw_dst == id_rt) ? mw_val : rf[id_rt];

  always_ff @(posedge clk) begin
    if (rst) begin
      de_v      <= 1'b0;
      de_alu    <= ALU_ADD;
      de_useimm <= 1'b0;
      de_ld     <= 1'b0;
      de_st     <= 1'b0;
      de_wen    <= 1'b0;
      de_dst    <= '0;
      de_a      <= '0;
      de_b      <= '0;
      de_imm    <= '0;
    end else begin
      de_v      <= fd_v;
      de_alu    <= id_alu;
      de_useimm <= id_useimm;
      de_ld     <= id_ld;
      de_st     <= id_st;
      de_wen    <= id_wen;
      de_dst    <= id_dst;
      de_a      <= id_a;
      de_b      <= id_b;
      de_imm    <= id_imm;
    end
  end

  // ---------------- execute ----------------
  assign ex_opb = de_useimm ? de_imm : de_b;

  always_comb begin
    case (de_alu)
      ALU_SUB: ex_res = de_a - ex_opb;
      ALU_AND: ex_res = de_a & ex_opb;
      ALU_OR:  ex_res = de_a | ex_opb;
      ALU_XOR: ex_res = de_a ^ ex_opb;
      ALU_SLT: ex_res = {{(XLEN-1){1'b0}}, $signed(de_a) < $signed(ex_opb)};
      default: ex_res = de_a + ex_opb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      em_v   <= 1'b0;
      em_ld  <= 1'b0;
      em_st  <= 1'b0;
      em_wen <= 1'b0;
      em_dst <= '0;
      em_res <= '0;
      em_sd  <= '0;
    end else begin
      em_v   <= de_v;
      em_ld  <= de_ld;
      em_st  <= de_st;
      em_wen <= de_wen;
      em_dst <= de_dst;
      em_res <= ex_res;
      em_sd  <= de_b;
    end
  end

  // ---------------- memory ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mw_v   <= 1'b0;
      mw_wen <= 1'b0;
      mw_dst <= '0;
      mw_val <= '0;
    end else begin
      mw_v   <= em_v;
      mw_wen <= em_wen;
      mw_dst <= em_dst;
      mw_val <= em_ld ? mem_rdata : em_res;
    end
  end

  // ---------------- write-back ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wb_wr) begin
      rf[mw_dst] <= mw_val;
    end
  end

  assign ret_valid = mw_v;
  assign ret_we    = wb_wr;
  assign ret_rd    = mw_dst;
  assign ret_data  = mw_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_count    <= '0;
      bubble_count <= '0;
    end else begin
      ret_count    <= ret_count + CW'(mw_v);
      bubble_count <= bubble_count + CW'(stall);
    end
  end

endmodule

module pipe5_shared_chk #(
  parameter int AW = 10,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          fd_v,
  input logic [AW-1:0] pc,
  input logic          mem_wen,
  input logic          ret_valid,
  input logic          ret_we,
  input logic [4:0]    ret_rd,
  input logic [CW-1:0] ret_count,
  input logic [CW-1:0] bubble_count
);

  a_r8_fetch_skipped: assert property (@(posedge clk) disable iff (rst)
    stall |=> !fd_v);

  a_r8_pc_held: assert property (@(posedge clk) disable iff (rst)
    stall |=> pc == $past(pc));

  a_r7_pc_steps: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (pc - $past(pc)) == AW'(1));

  a_r11_store_not_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_wen |=> !fd_v);

  a_r5_zero_dest: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_rd == 5'd0) |-> !ret_we);

  a_r10_bubble_tally: assert property (@(posedge clk) disable iff (rst)
    stall |=> bubble_count == $past(bubble_count) + CW'(1));

  a_r10_retire_idle: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> ret_count == $past(ret_count));

endmodule

bind pipe5_shared pipe5_shared_chk #(.AW(AW), .CW(CW)) u_pipe5_shared_chk (
  .clk(clk), .rst(rst), .stall(stall), .fd_v(fd_v), .pc(pc),
  .mem_wen(mem_wen), .ret_valid(ret_valid), .ret_we(ret_we),
  .ret_rd(ret_rd), .ret_count(ret_count), .bubble_count(bubble_count)
);

// File: tb/test_pipe5_shared.sv
`timescale 1ns/1ps
module test_pipe5_shared;
  localparam int AW = 10;
  localparam int XLEN = 32;
  localparam int CW = 32;
  localparam int MW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0]   mem_addr;
  logic            mem_wen;
  logic [XLEN-1:0] mem_wdata, mem_rdata;
  logic            ret_valid, ret_we;
  logic [4:0]      ret_rd;
  logic [XLEN-1:0] ret_data;
  logic [CW-1:0]   ret_count, bubble_count;

  pipe5_shared #(.AW(AW), .XLEN(XLEN), .CW(CW)) i_pipe5_shared (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wen(mem_wen),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ret_valid(ret_valid),
    .ret_we(ret_we), .ret_rd(ret_rd), .ret_data(ret_data),
    .ret_count(ret_count), .bubble_count(bubble_count)
  );

  logic [31:0] img [MW];
  logic [31:0] ram [MW];
  logic [31:0] mmem [MW];
  logic [31:0] mreg [32];

  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MW; i++) ram[i] <= img[i];
    end else if (mem_wen) begin
      ram[mem_addr] <= mem_wdata;
    end
  end

  typedef struct {
    string       tag;
    bit          we;
    logic [4:0]  rd;
    logic [31:0] val;
    int          cyc;
    int          bub;
  } exp_t;

  exp_t q[$];
  int unsigned blk_addr [int];
  bit          blk_st   [int];
  logic [31:0] blk_dat  [int];
  int sched_t, lpc, nls;
  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(int fn, int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] ity(int op, int rt, int rs, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic begin_prog();
    for (int i = 0; i < MW; i++) begin img[i] = '0; mmem[i] = '0; end
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    q.delete(); blk_addr.delete(); blk_st.delete(); blk_dat.delete();
    sched_t = 0; lpc = 0; nls = 0;
  endtask

  task automatic poke(int a, logic [31:0] v);
    img[a] = v; mmem[a] = v;
  endtask

  // driver: place the word, run the reference model, push the expectation
  task automatic emit(string tag, logic [31:0] ir);
    exp_t it;
    int f;
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, dst;
    logic [31:0] a, b, imm, val;
    logic [AW-1:0] da;
    bit we, ls;
    poke(lpc, ir);
    lpc++;
    while (blk_addr.exists(sched_t)) sched_t++;
    f = sched_t;
    sched_t++;
    op = ir[31:26]; rs = ir[25:21]; rt = ir[20:16]; rd = ir[15:11]; fn = ir[5:0];
    a = mreg[rs]; b = mreg[rt]; imm = {{16{ir[15]}}, ir[15:0]};
    we = 0; ls = 0; dst = rt; val = '0;
    da = AW'(a + imm);
    case (op)
      6'h00: begin
        dst = rd; we = 1;
        case (fn)
          6'd0: val = a + b;
          6'd1: val = a - b;
          6'd2: val = a & b;
          6'd3: val = a | b;
          6'd4: val = a ^ b;
          6'd5: val = {31'd0, $signed(a) < $signed(b)};
          default: we = 0;
        endcase
      end
      6'h01: begin we = 1; val = a + imm; end
      6'h02: begin we = 1; ls = 1; val = mmem[da]; end
      6'h03: begin ls = 1; end
      default: ;
    endcase
    if (dst == 0) we = 0;
    if (ls) begin
      blk_addr[f + 3] = da;
      blk_st[f + 3]   = (op == 6'h03);
      blk_dat[f + 3]  = b;
      if (op == 6'h03) mmem[da] = b;
      nls++;
    end
    if (we) mreg[dst] = val;
    it.tag = tag; it.we = we; it.rd = dst; it.val = val;
    it.cyc = f + 4; it.bub = nls;
    q.push_back(it);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) emit("R7", 32'h0);
  endtask

  // monitor: drive reset, then compare the port and retire stream each cycle
  task automatic run_prog();
    int nf = 0;
    int idx = 0;
    int tail = 0;
    exp_t it;
    logic [AW-1:0] ea;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ret_valid", 64'(ret_valid), 64'(0));
    chk("R1 reset mem_wen", 64'(mem_wen), 64'(0));
    chk("R1 reset mem_addr", 64'(mem_addr), 64'(0));
    chk("R1 reset ret_count", 64'(ret_count), 64'(0));
    chk("R1 reset bubble_count", 64'(bubble_count), 64'(0));
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      #1;
      if (blk_addr.exists(c)) begin
        ea = AW'(blk_addr[c]);
        chk("R8 data address on port", 64'(mem_addr), 64'(ea));
        chk("R11 store strobe", 64'(mem_wen), 64'(blk_st[c]));
        if (blk_st[c]) chk("R11 store data", 64'(mem_wdata), 64'(blk_dat[c]));
      end else begin
        chk(c == 0 ? "R1 first fetch address" : "R9 fetch address",
            64'(mem_addr), 64'(AW'(nf)));
        chk("R11 no strobe on fetch", 64'(mem_wen), 64'(0));
        nf++;
      end
      if (ret_valid && q.size() > 0) begin
        it = q.pop_front();
        chk(it.bub == 0 ? "R7 retire cycle" : "R8 retire cycle", 64'(c), 64'(it.cyc));
        chk({it.tag, " write enable"}, 64'(ret_we), 64'(it.we));
        if (it.we) begin
          chk({it.tag, " dest"}, 64'(ret_rd), 64'(it.rd));
          chk({it.tag, " value"}, 64'(ret_data), 64'(it.val));
        end
        chk("R10 retired count", 64'(ret_count), 64'(idx));
        chk("R10 bubble count", 64'(bubble_count), 64'(it.bub));
        idx++;
      end
      if (q.size() == 0) tail++;
      if (tail > 3) break;
      @(negedge clk);
    end
    chk("R7 all instructions retired", 64'(q.size()), 64'(0));
    for (int a = 'h1F0; a < 'h210; a++)
      chk("R11 memory image", 64'(ram[a]), 64'(mmem[a]));
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // program 1: arithmetic only
    begin_prog();
    emit("R3", ity(1, 1, 0, 5));
    emit("R3", ity(1, 2, 0, -3));
    emit("R3", ity(1, 4, 0, 'h7F5));
    nops(1);
    emit("R6", rr(0, 3, 1, 2));
    emit("R2", rr(1, 5, 1, 2));
    emit("R2", rr(2, 6, 1, 4));
    emit("R2", rr(3, 7, 2, 4));
    emit("R2", rr(4, 8, 1, 2));
    emit("R2", rr(5, 9, 2, 1));
    emit("R2", rr(5, 10, 1, 2));
    emit("R5", rr(0, 0, 1, 1));
    nops(2);
    emit("R5", rr(0, 11, 0, 1));
    emit("R12", {6'h3F, 26'h0ABCDEF});
    emit("R12", rr(9, 12, 1, 1));
    nops(3);
    run_prog();

    // program 2: back-to-back memory traffic
    begin_prog();
    poke('h208, 32'h1234_5678);
    poke('h1FF, 32'hCAFE_0001);
    emit("R3", ity(1, 1, 0, 'h200));
    emit("R3", ity(1, 2, 0, 77));
    emit("R3", ity(1, 3, 0, -1));
    nops(1);
    emit("R9", ity(3, 2, 1, 0));
    emit("R9", ity(3, 3, 1, 1));
    emit("R4", ity(2, 4, 1, 0));
    emit("R4", ity(2, 5, 1, 8));
    nops(2);
    emit("R2", rr(0, 6, 4, 5));
    emit("R4", ity(2, 7, 1, -1));
    nops(1);
    emit("R11", ity(3, 6, 1, 2));
    emit("R4", ity(2, 9, 1, 'h3FF));
    nops(4);
    run_prog();

    // program 3: isolated accesses with varied spacing
    begin_prog();
    poke('h1F4, 32'h0000_00A5);
    emit("R3", ity(1, 1, 0, 'h1F4));
    nops(2);
    emit("R4", ity(2, 2, 1, 0));
    nops(1);
    emit("R8", ity(2, 3, 1, 0));
    nops(2);
    emit("R11", ity(3, 3, 1, 3));
    nops(3);
    emit("R4", ity(2, 5, 1, 3));
    nops(4);
    run_prog();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule